// File: doc/BRIEF.md
# Burst Latency and WAIT Generator

This block is the device-side timing core of a synchronous burst memory port. A small configuration register holds a 3-bit latency code, a fixed/variable latency mode bit, a WAIT timing bit and a WAIT polarity bit. When the host opens a burst, the block counts clocks up to the first data beat. In variable mode, a refresh collision stretches that count. After that the block raises a data-valid strobe once per clock and drives WAIT to cover every clock that carries no data.

The latency count is extended only in variable mode. In that mode a collision adds exactly the gap between the worst-case latency and the normal latency, and only once per access. A row-boundary signal can insert a fixed number of wait states in the middle of a burst. The WAIT pin can either be aligned with the data it describes or lead it by one clock, and it can be active-low or active-high. Configuration writes are held in the register and are picked up only when the next burst starts.

Top module: `burstWaitGen`

## Requirements
- R1: Codes 3'b010, 3'b011 and 3'b100 on `cfgLatCode` give a latency L of 2, 3 and 4. If `burstStart` is sampled at clock edge k, `beatValid` goes high at edge k+L+1. With no refresh collision and no row wait, there are no beats before that edge.
- R2: The codes 000, 001, 101, 110 and 111 are reserved and behave as L=3. Writing any of them sets `cfgError` at the write edge, and the flag stays high until reset.
- R3: With `cfgFixed`=0, a `refreshHit` sampled at any edge from k through k+L moves the first beat to edge k+2L+1. Any further `refreshHit` in the same burst has no effect.
- R4: With `cfgFixed`=1, `refreshHit` has no effect. The first beat is at edge k+L+1.
- R5: After the first beat, `beatValid` is high every clock. When `burstEnd` is sampled at edge e, `beatValid` is low from edge e+1 onward.
- R6: `rowEdge` sampled at an edge m in the data phase makes `beatValid` low from edge m+1 for ROW_STALL clocks. Beats resume at edge m+ROW_STALL+1.
- R7: With `cfgWaitEarly`=0, WAIT is active in exactly those clocks of a burst (from edge k+1 up to edge e) where `beatValid` is low.
- R8: With `cfgWaitEarly`=1, WAIT in each clock shows the value that R7 gives for the following clock. WAIT becomes active at edge k and inactive at edge e.
- R9: `cfgWaitHigh`=1 makes WAIT active-high and 0 makes it active-low. Outside a burst, WAIT sits at its inactive level.
- R10: Configuration written while a burst runs does not change that burst. The burst that follows uses it. A `burstStart` during a burst is ignored. After reset the configuration is code 3'b011, variable, aligned, active-low.
- R11: After reset `beatValid` is 0, `waitOut` is 1 and `cfgError` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for the configuration register |
| cfgLatCode | input | 3 | Latency code to store |
| cfgFixed | input | 1 | 1 = fixed latency, 0 = variable latency |
| cfgWaitEarly | input | 1 | 1 = WAIT leads data by one clock, 0 = aligned |
| cfgWaitHigh | input | 1 | 1 = WAIT active-high, 0 = active-low |
| burstStart | input | 1 | Opens a burst when the block is idle |
| burstEnd | input | 1 | Closes the running burst |
| refreshHit | input | 1 | Internal refresh collision |
| rowEdge | input | 1 | Row boundary reached, insert wait states |
| beatValid | output | 1 | A data beat is transferred in this clock |
| waitOut | output | 1 | WAIT pin level |
| cfgError | output | 1 | Sticky flag: a reserved latency code was written |

## Verification
The bench builds the block with ROW_STALL=2, which keeps each burst short. This makes it possible to sweep every latency code, every combination of the three mode bits, and refresh collisions at every offset across the latency window and one clock past it, with row stalls mixed in. In each burst the bench follows `beatValid` and `waitOut` clock by clock against values it works out from the start edge, the latency, the collision offset and the end edge. A last pair of bursts writes a new configuration in the middle of a burst, issues a stray start, and then checks that the following burst uses the new settings.

// File: rtl/burstWaitPkg.sv
`timescale 1ns/1ps
package burstWaitPkg;
  localparam int CODE_W    = 3;
  localparam int MAX_LAT   = 4;
  localparam int LAT_W     = $clog2(MAX_LAT + 1);
  localparam int STALL_MAX = 15;
  localparam int CNT_TOP   = (2 * MAX_LAT > STALL_MAX) ? 2 * MAX_LAT : STALL_MAX;
  localparam int CNT_W     = $clog2(CNT_TOP + 1);

  typedef struct packed {
    logic [CODE_W-1:0] latCode;
    logic              fixedMode;
    logic              waitEarly;
    logic              waitHigh;
  } cfgT;

  localparam cfgT CFG_RESET = '{latCode: CODE_W'(3), fixedMode: 1'b0,
                                waitEarly: 1'b0, waitHigh: 1'b0};

  typedef struct packed {
    logic loadCfg;
    logic busy;
    logic beat;
  } strobeT;

  typedef enum logic [1:0] {PH_IDLE, PH_LAT, PH_DATA, PH_STALL} phaseT;

  function automatic logic codeReserved(input logic [CODE_W-1:0] code);
    return !(code == CODE_W'(2) || code == CODE_W'(3) || code == CODE_W'(4));
  endfunction

  function automatic logic [LAT_W-1:0] decodeLat(input logic [CODE_W-1:0] code);
    logic [LAT_W-1:0] lat;
    case (code)
      CODE_W'(2): lat = LAT_W'(2);
      CODE_W'(4): lat = LAT_W'(4);
      default:    lat = LAT_W'(3);
    endcase
    return lat;
  endfunction
endpackage

// File: rtl/blwDatapath.sv
`timescale 1ns/1ps
module blwDatapath
  import burstWaitPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  cfgT              cfgIn,
  input  strobeT           strobes,
  output logic [LAT_W-1:0] nextLat,
  output logic             nextFixed,
  output logic [LAT_W-1:0] curLat,
  output logic             curFixed,
  output logic             beatValid,
  output logic             waitOut,
  output logic             cfgError
);
  cfgT  storedCfg;
  cfgT  activeCfg;
  logic beatQ;
  logic stallQ;
  logic errQ;
  logic stallNow;
  logic waitAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storedCfg <= CFG_RESET;
      activeCfg <= CFG_RESET;
      beatQ     <= 1'b0;
      stallQ    <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        storedCfg <= cfgIn;
        errQ      <= errQ | codeReserved(cfgIn.latCode);
      end
      if (strobes.loadCfg) activeCfg <= storedCfg;
      beatQ  <= strobes.beat;
      stallQ <= strobes.busy & ~strobes.beat;
    end
  end

  always_comb begin
    stallNow  = strobes.busy & ~strobes.beat;
    waitAct   = activeCfg.waitEarly ? stallNow : stallQ;
    waitOut   = activeCfg.waitHigh ? waitAct : ~waitAct;
    nextLat   = decodeLat(storedCfg.latCode);
    nextFixed = storedCfg.fixedMode;
    curLat    = decodeLat(activeCfg.latCode);
    curFixed  = activeCfg.fixedMode;
    beatValid = beatQ;
    cfgError  = errQ;
  end
endmodule

// File: rtl/blwControl.sv
`timescale 1ns/1ps
module blwControl
  import burstWaitPkg::*;
#(
  parameter int ROW_STALL = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             burstStart,
  input  logic             burstEnd,
  input  logic             refreshHit,
  input  logic             rowEdge,
  input  logic [LAT_W-1:0] nextLat,
  input  logic             nextFixed,
  input  logic [LAT_W-1:0] curLat,
  input  logic             curFixed,
  output strobeT           strobes
);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);
  localparam logic [CNT_W-1:0] STALL_LOAD = CNT_W'(ROW_STALL - 1);

  phaseT            phase, phaseNext;
  logic [CNT_W-1:0] remain, remainNext;
  logic             hitUsed, hitUsedNext;
  logic             startHit, latHit;

  always_comb begin
    startHit    = refreshHit & ~nextFixed;
    latHit      = refreshHit & ~curFixed & ~hitUsed;
    phaseNext   = phase;
    remainNext  = remain;
    hitUsedNext = hitUsed;
    case (phase)
      PH_IDLE: if (burstStart) begin
        phaseNext   = PH_LAT;
        hitUsedNext = startHit;
        remainNext  = startHit ? (CNT_W'(nextLat) << 1) - ONE : CNT_W'(nextLat) - ONE;
      end
      PH_LAT: begin
        if (latHit) begin
          remainNext  = remain + CNT_W'(curLat) - ONE;
          hitUsedNext = 1'b1;
        end else if (remain == '0) begin
          phaseNext = PH_DATA;
        end else begin
          remainNext = remain - ONE;
        end
      end
      PH_DATA: if (rowEdge) begin
        phaseNext  = PH_STALL;
        remainNext = STALL_LOAD;
      end
      PH_STALL: begin
        if (remain == '0) phaseNext = PH_DATA;
        else              remainNext = remain - ONE;
      end
      default: phaseNext = PH_IDLE;
    endcase
    if (phase != PH_IDLE && burstEnd) begin
      phaseNext   = PH_IDLE;
      remainNext  = '0;
      hitUsedNext = 1'b0;
    end
    strobes.loadCfg = (phase == PH_IDLE) && burstStart;
    strobes.busy    = (phase != PH_IDLE);
    strobes.beat    = (phase == PH_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      remain  <= '0;
      hitUsed <= 1'b0;
    end else begin
      phase   <= phaseNext;
      remain  <= remainNext;
      hitUsed <= hitUsedNext;
    end
  end
endmodule

// File: rtl/burstWaitGen.sv
`timescale 1ns/1ps
module burstWaitGen
  import burstWaitPkg::*;
#(
  parameter int ROW_STALL = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgLatCode,
  input  logic        cfgFixed,
  input  logic        cfgWaitEarly,
  input  logic        cfgWaitHigh,
  input  logic        burstStart,
  input  logic        burstEnd,
  input  logic        refreshHit,
  input  logic        rowEdge,
  output logic        beatValid,
  output logic        waitOut,
  output logic        cfgError
);
  cfgT              cfgIn;
  strobeT           strobes;
  logic [LAT_W-1:0] nextLat, curLat;
  logic             nextFixed, curFixed;

  assign cfgIn = '{latCode: cfgLatCode, fixedMode: cfgFixed,
                   waitEarly: cfgWaitEarly, waitHigh: cfgWaitHigh};

  blwControl #(.ROW_STALL(ROW_STALL)) u_ctrl (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .burstEnd(burstEnd),
    .refreshHit(refreshHit), .rowEdge(rowEdge), .nextLat(nextLat),
    .nextFixed(nextFixed), .curLat(curLat), .curFixed(curFixed),
    .strobes(strobes)
  );

  blwDatapath u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIn(cfgIn), .strobes(strobes),
    .nextLat(nextLat), .nextFixed(nextFixed), .curLat(curLat), .curFixed(curFixed),
    .beatValid(beatValid), .waitOut(waitOut), .cfgError(cfgError)
  );
endmodule

// File: rtl/blwChecker.sv
`timescale 1ns/1ps
module blwChecker
  import burstWaitPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             beatValid,
  input logic             waitOut,
  input logic             cfgError,
  input logic             busy,
  input logic             beat,
  input phaseT            phase,
  input logic [CNT_W-1:0] remain,
  input logic [LAT_W-1:0] actLat,
  input logic             actFixed,
  input logic             actEarly,
  input logic             actHigh
);
  assert_beat_inside_burst_R5: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> $past(busy));

  assert_error_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  assert_fixed_no_stretch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LAT && actFixed) |-> (CNT_W'(actLat) > remain));

  assert_variable_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LAT) |-> ((CNT_W'(actLat) << 1) > remain));

  assert_aligned_wait_off_on_beat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!actEarly && beatValid) |-> (waitOut == !actHigh));

  assert_idle_wait_inactive_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (waitOut == !actHigh));

  assert_no_beat_in_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LAT) |-> !beat);
endmodule

bind burstWaitGen blwChecker u_chk (
  .clk(clk), .rstN(rstN), .beatValid(beatValid), .waitOut(waitOut),
  .cfgError(cfgError), .busy(strobes.busy), .beat(strobes.beat),
  .phase(u_ctrl.phase), .remain(u_ctrl.remain), .actLat(curLat),
  .actFixed(curFixed), .actEarly(u_dp.activeCfg.waitEarly),
  .actHigh(u_dp.activeCfg.waitHigh)
);

// File: tb/burstWaitGen_tb.sv
`timescale 1ns/1ps
module burstWaitGen_tb;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0, cfgFixed = 1'b0, cfgWaitEarly = 1'b0, cfgWaitHigh = 1'b0;
  logic [2:0] cfgLatCode = 3'd0;
  logic burstStart = 1'b0, burstEnd = 1'b0, refreshHit = 1'b0, rowEdge = 1'b0;
  logic beatValid, waitOut, cfgError;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int stCode = 3;
  bit stFx = 1'b0, stEr = 1'b0, stPl = 1'b0;
  bit acEr = 1'b0, acPl = 1'b0;
  int kG = -1000, eG = -1000, mG = -1000, leffG = 0;
  bit rowG = 1'b0;
  bit expErr = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burstWaitGen #(.ROW_STALL(S)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLatCode(cfgLatCode),
    .cfgFixed(cfgFixed), .cfgWaitEarly(cfgWaitEarly), .cfgWaitHigh(cfgWaitHigh),
    .burstStart(burstStart), .burstEnd(burstEnd), .refreshHit(refreshHit),
    .rowEdge(rowEdge), .beatValid(beatValid), .waitOut(waitOut), .cfgError(cfgError)
  );

  function automatic int latOf(input int c);
    return (c == 2) ? 2 : ((c == 4) ? 4 : 3);
  endfunction

  function automatic bit isReserved(input int c);
    return !(c == 2 || c == 3 || c == 4);
  endfunction

  function automatic bit beatAt(input int t);
    return (t >= kG + leffG) && (t < eG) && !(rowG && t >= mG && t < mG + S);
  endfunction

  function automatic bit stallAt(input int t);
    return (t >= kG) && (t < eG) && !beatAt(t);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual=%0b expected=%0b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic checkOutputs(input int t, input string beatTag, input string waitTag);
    bit wa;
    check(beatTag, beatValid, beatAt(t - 1), "beatValid");
    wa = acEr ? stallAt(t) : stallAt(t - 1);
    check(waitTag, waitOut, acPl ? wa : !wa, "waitOut");
    check("R2", cfgError, expErr, "cfgError");
  endtask

  task automatic runBurst(input int code, input bit fx, input bit er, input bit pl,
                          input bit doWrite, input int refOff, input bit rowOn,
                          input bit mid, input string tagOver);
    int lat, ext, t;
    bit capEr, capPl, capFx;
    string bt, wt;
    if (doWrite) begin
      cfgLatCode = 3'(code); cfgFixed = fx; cfgWaitEarly = er; cfgWaitHigh = pl;
      cfgWrEn = 1'b1;
      @(negedge clk);
      cfgWrEn = 1'b0;
      stCode = code; stFx = fx; stEr = er; stPl = pl;
      expErr = expErr | isReserved(code);
      checkOutputs(cyc, "R9", "R9");
    end
    lat = latOf(stCode);
    ext = (!stFx && refOff >= 0 && refOff <= lat) ? lat : 0;
    capEr = stEr; capPl = stPl; capFx = stFx;
    burstStart = 1'b1;
    refreshHit = (refOff == 0);
    kG = cyc + 1;
    leffG = lat + ext;
    rowG = rowOn;
    mG = kG + leffG + 2;
    eG = kG + leffG + 6 + (rowOn ? S : 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      t = cyc;
      if (t == kG) begin acEr = capEr; acPl = capPl; end
      if (tagOver != "") bt = tagOver;
      else if (isReserved(stCode) && t - 1 <= kG + leffG) bt = "R2";
      else if (t - 1 <= kG + leffG) bt = capFx ? "R4" : ((ext != 0) ? "R3" : "R1");
      else if (rowOn && t - 1 >= mG && t - 1 <= mG + S) bt = "R6";
      else bt = "R5";
      if (tagOver != "") wt = tagOver;
      else if (t < kG || t > eG + 1) wt = "R9";
      else wt = acEr ? "R8" : "R7";
      checkOutputs(t, bt, wt);
      cfgWrEn    = 1'b0;
      burstStart = mid && (t + 1 == kG + 3);
      refreshHit = (refOff >= 0) && ((t + 1 == kG + refOff) || (t + 1 == kG + refOff + 2));
      rowEdge    = rowOn && (t + 1 == mG);
      burstEnd   = (t + 1 == eG);
      if (mid && t + 1 == kG + 2) begin
        cfgLatCode = 3'd4; cfgFixed = 1'b1; cfgWaitEarly = !capEr; cfgWaitHigh = !capPl;
        cfgWrEn = 1'b1;
        stCode = 4; stFx = 1'b1; stEr = !capEr; stPl = !capPl;
      end
      if (t >= eG + 2) break;
    end
    burstStart = 1'b0; refreshHit = 1'b0; rowEdge = 1'b0; burstEnd = 1'b0; cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int order[8];
    order = '{2, 3, 4, 0, 1, 5, 6, 7};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    check("R11", beatValid, 1'b0, "beatValid after reset");
    check("R11", waitOut, 1'b1, "waitOut after reset");
    check("R11", cfgError, 1'b0, "cfgError after reset");
    // R10: reset configuration is code 011, variable, aligned, active low
    runBurst(3, 0, 0, 0, 1'b0, 1, 0, 1'b0, "R10");
    for (int ci = 0; ci < 8; ci++) begin
      for (int cf = 0; cf < 8; cf++) begin
        for (int ro = -1; ro <= latOf(order[ci]) + 1; ro++) begin
          runBurst(order[ci], cf[0], cf[1], cf[2], 1'b1, ro, (ro % 2 == 0), 1'b0, "");
        end
      end
    end
    // R10: mid-burst configuration write and stray start
    runBurst(2, 0, 0, 0, 1'b1, -1, 0, 1'b1, "R10");
    runBurst(0, 0, 0, 0, 1'b0, 0, 0, 1'b0, "R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule